// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the serial engine of an SPI master. It takes words from a transmit stream, shifts each one out on `mosi` and captures `miso` into a received word of the same size, which it offers on a receive stream. Static configuration pins set the word size (8, 12, 16 or 32 bits), the serial clock divider, the serial clock idle level, which clock edge launches data, the bit order, the inactive chip-select level and whether chip select is driven by the engine or copied from a software level. A frame holds one word, or, in multi-word mode, the word-count-minus-one value plus one.

The transmit side is a valid/ready sink. `tx_ready` is high in idle while `tx_en` is set, and for one cycle between words when another word of the frame is due. A word moves on a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` never depends on `tx_valid`. If no word is offered when one is due, the frame is cut short. The receive side is a valid/ready source. `rx_valid` stays high with stable `rx_data` until `rx_ready` accepts the word. If a new word completes while the previous one is still unaccepted, the new word is lost and the overflow flag rises.

Three sticky status flags mark frame end, receive overflow and transmit underflow. Each flag is cleared by a one on its clear pin. The interrupt output is high while any flag whose enable is set is high.

Top module: `spi_xfer_engine`

## Requirements
- R1: `cfg_wsize` selects the bits per word: 0 gives 8, 1 gives 12, 2 gives 16 and 3 gives 32. Each word takes exactly twice that many `sck` edges, and the received word has all bits above the word size at zero.
- R2: Consecutive `sck` edges within a word are `cfg_div`+1 clock cycles apart. Outside a frame, and after the last edge of a frame, `sck` rests at `cfg_clk_idle`.
- R3: With `cfg_drive_rise`=1, `mosi` is launched on rising `sck` edges and `miso` is captured on falling edges. With 0, the roles of the two edges are swapped. The first bit of each word is on `mosi` half an `sck` period before the first edge.
- R4: With `cfg_msb_first`=1, bit N-1 of the word is sent and received first. With 0, bit 0 goes first.
- R5: With `cfg_multi`=1, a frame carries `cfg_len_m1`+1 words. With 0, it carries one word and `cfg_len_m1` has no effect. Each word is taken once from the transmit stream and offered once on the receive stream.
- R6: With `cfg_cs_sw_mode`=0, `cs` is at the inverse of `cfg_cs_idle` from the first word load until half an `sck` period after the last edge, without release between words. Outside a frame it equals `cfg_cs_idle`.
- R7: With `cfg_cs_sw_mode`=1, `cs` equals `cfg_cs_sw_level` at all times.
- R8: Status bit 0 (frame end) sets when a frame ends normally. Chip select is already idle in that same cycle.
- R9: Status bit 1 (overflow) sets when a word completes while `rx_valid` is high and `rx_ready` is low. The new word is dropped, and the pending word and `rx_valid` are kept.
- R10: Status bit 2 (underflow) sets when a further word of a frame is due and `tx_valid` is low. The frame ends at once, chip select goes idle, and frame end does not set.
- R11: Status bits stay set until a 1 on the matching `sts_clr` bit clears them; clearing one bit leaves the others alone. `irq` is high exactly when some bit is set in both `sts` and `irq_en`.
- R12: With `tx_en`=0 no frame starts and `tx_ready` stays low in idle. With `rx_en`=0 received words are neither offered nor counted as overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wsize | input | 2 | Word size code |
| cfg_div | input | 16 | Half-period length minus one, in clocks |
| cfg_clk_idle | input | 1 | Serial clock idle level |
| cfg_drive_rise | input | 1 | 1: launch on rising edge, 0: on falling edge |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_cs_idle | input | 1 | Inactive chip-select level |
| cfg_cs_sw_mode | input | 1 | 1: chip select follows `cfg_cs_sw_level` |
| cfg_cs_sw_level | input | 1 | Chip-select level in software mode |
| cfg_multi | input | 1 | Multi-word frame enable |
| cfg_len_m1 | input | 16 | Words per frame minus one |
| tx_en | input | 1 | Transmit enable, allows frame start |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 3 | Per-flag interrupt enable |
| sts_clr | input | 3 | Write-one-to-clear strobes for the flags |
| sts | output | 3 | Sticky flags: bit 0 frame end, bit 1 overflow, bit 2 underflow |
| irq | output | 1 | Interrupt request |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine takes the transmit word |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | Received word offered |
| rx_ready | input | 1 | Receiver takes the word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select |

## Verification
A wrong bit counter or word-size decode shows up as a wrong number of `sck` edges in the same frame, and as shifted or truncated words on the wire and on `rx_data` once the first word ends. A wrong frame state shows up within half an `sck` period of the last edge: `cs` is released early or late, `sck` is left at the wrong level, or the wrong flag is raised. A broken half-period counter changes the spacing of the first two edges. A broken flag store shows up on `irq` the cycle after a clear or a masking change.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } xfer_state_e;

  localparam int STS_W    = 3;
  localparam int STS_FEND = 0;
  localparam int STS_OVF  = 1;
  localparam int STS_UNF  = 2;

  // bits per word for a size code
  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd12;
      2'd2:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/spi_xfer_clkgen.sv
`timescale 1ns/1ps
module spi_xfer_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_xfer_shifter.sv
`timescale 1ns/1ps
module spi_xfer_shifter #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic [IDX_W-1:0]  load_pos,
  input  logic              drive,
  input  logic              sample,
  input  logic [IDX_W-1:0]  bit_pos,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] txw, rxw;
  logic              mosi_q;

  always_comb begin
    rx_word = rxw;
    if (sample) rx_word[bit_pos] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txw    <= '0;
      rxw    <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      txw    <= load_word;
      rxw    <= '0;
      mosi_q <= load_word[load_pos];
    end else begin
      if (drive)  mosi_q <= txw[bit_pos];
      if (sample) rxw    <= rx_word;
    end
  end

  assign mosi = mosi_q;
endmodule

// File: rtl/spi_xfer_status.sv
`timescale 1ns/1ps
module spi_xfer_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] sts,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | set;
  end

  assign irq = |(sts & en);
endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_wsize,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_clk_idle,
  input  logic              cfg_drive_rise,
  input  logic              cfg_msb_first,
  input  logic              cfg_cs_idle,
  input  logic              cfg_cs_sw_mode,
  input  logic              cfg_cs_sw_level,
  input  logic              cfg_multi,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [STS_W-1:0]  irq_en,
  input  logic [STS_W-1:0]  sts_clr,
  output logic [STS_W-1:0]  sts,
  output logic              irq,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = IDX_W + 2;

  xfer_state_e      state;
  logic [DIV_W-1:0] f_div;
  logic [CNT_W-1:0] f_n;
  logic             f_msb, f_drive_rise;
  logic [LEN_W-1:0] words_left;
  logic [CNT_W-1:0] edge_cnt, smp_cnt;
  logic             sck_q;
  logic             rx_valid_q;
  logic [DATA_W-1:0] rx_data_q;

  logic tick, start, in_edge, edge_is_drive, last_edge;
  logic drive, sample, more, wait_tick, fetch, underrun, load, overflow;
  logic [CNT_W-1:0] live_n, n_sel;
  logic             msb_sel;
  logic [IDX_W-1:0] load_pos, bit_pos;
  logic [DATA_W-1:0] rx_word;

  assign live_n   = CNT_W'(word_bits(cfg_wsize));
  assign n_sel    = (state == ST_IDLE) ? live_n : f_n;
  assign msb_sel  = (state == ST_IDLE) ? cfg_msb_first : f_msb;
  assign load_pos = msb_sel ? IDX_W'(n_sel - CNT_W'(1)) : '0;
  assign bit_pos  = f_msb ? IDX_W'(f_n - CNT_W'(1) - smp_cnt) : IDX_W'(smp_cnt);

  assign start         = (state == ST_IDLE) && tx_en && tx_valid;
  assign in_edge       = (state == ST_RUN) && tick;
  assign edge_is_drive = (~sck_q == f_drive_rise);
  assign last_edge     = in_edge && (edge_cnt == ((f_n << 1) - CNT_W'(1)));
  assign drive         = in_edge && edge_is_drive && (smp_cnt < f_n);
  assign sample        = in_edge && !edge_is_drive;
  assign more          = (words_left != '0);
  assign wait_tick     = (state == ST_WAIT) && tick;
  assign fetch         = wait_tick && more && tx_valid;
  assign underrun      = wait_tick && more && !tx_valid;
  assign load          = start || fetch;
  assign overflow      = last_edge && rx_en && rx_valid_q && !rx_ready;
  assign tx_ready      = ((state == ST_IDLE) && tx_en) || (wait_tick && more);

  spi_xfer_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .div(f_div), .tick(tick)
  );

  spi_xfer_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(tx_data),
    .load_pos(load_pos), .drive(drive), .sample(sample), .bit_pos(bit_pos),
    .miso(miso), .mosi(mosi), .rx_word(rx_word)
  );

  spi_xfer_status #(.W(STS_W)) u_sts (
    .clk(clk), .rst_n(rst_n),
    .set({underrun, overflow, wait_tick && !more}),
    .clr(sts_clr), .en(irq_en), .sts(sts), .irq(irq)
  );

  // frame sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      f_div        <= '0;
      f_n          <= CNT_W'(8);
      f_msb        <= 1'b1;
      f_drive_rise <= 1'b0;
      words_left   <= '0;
      edge_cnt     <= '0;
      smp_cnt      <= '0;
      sck_q        <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sck_q <= cfg_clk_idle;
          if (start) begin
            f_div        <= cfg_div;
            f_n          <= live_n;
            f_msb        <= cfg_msb_first;
            f_drive_rise <= cfg_drive_rise;
            words_left   <= cfg_multi ? cfg_len_m1 : '0;
            edge_cnt     <= '0;
            smp_cnt      <= '0;
            state        <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            sck_q    <= ~sck_q;
            edge_cnt <= edge_cnt + CNT_W'(1);
            if (sample)    smp_cnt <= smp_cnt + CNT_W'(1);
            if (last_edge) state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (fetch) begin
              words_left <= words_left - LEN_W'(1);
              edge_cnt   <= '0;
              smp_cnt    <= '0;
              state      <= ST_RUN;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // receive holding stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      if (rx_valid_q && rx_ready) rx_valid_q <= 1'b0;
      if (last_edge && rx_en && (!rx_valid_q || rx_ready)) begin
        rx_valid_q <= 1'b1;
        rx_data_q  <= rx_word;
      end
    end
  end

  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign sck      = sck_q;
  assign cs       = cfg_cs_sw_mode ? cfg_cs_sw_level
                  : ((state != ST_IDLE) ? ~cfg_cs_idle : cfg_cs_idle);
endmodule

// File: rtl/spi_xfer_checker.sv
`timescale 1ns/1ps
module spi_xfer_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_div,
  input logic        cfg_cs_idle,
  input logic        cfg_cs_sw_mode,
  input logic        tx_en,
  input logic [2:0]  sts,
  input logic [2:0]  sts_clr,
  input logic        tx_ready,
  input logic [31:0] rx_data,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        sck,
  input logic        cs
);
  // R11
  sticky_fend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !sts_clr[0]) |=> sts[0]);

  // R11
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !sts_clr[1]) |=> sts[1]);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R2
  sck_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && (cfg_div != 16'd0) && (cs != cfg_cs_idle) && !cfg_cs_sw_mode)
      |=> $stable(sck));

  // R12
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !cfg_cs_sw_mode && (cs == cfg_cs_idle)) |-> !tx_ready);

  // R8
  fend_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts[0]) && !cfg_cs_sw_mode) |-> (cs == cfg_cs_idle));
endmodule

bind spi_xfer_engine spi_xfer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cs_idle(cfg_cs_idle),
  .cfg_cs_sw_mode(cfg_cs_sw_mode), .tx_en(tx_en), .sts(sts), .sts_clr(sts_clr),
  .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .sck(sck), .cs(cs)
);

// File: tb/spi_xfer_engine_test.sv
`timescale 1ns/1ps
module spi_xfer_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  cfg_wsize = 2'd0;
  logic [15:0] cfg_div = 16'd1;
  logic        cfg_clk_idle = 1'b0, cfg_drive_rise = 1'b0, cfg_msb_first = 1'b1;
  logic        cfg_cs_idle = 1'b1, cfg_cs_sw_mode = 1'b0, cfg_cs_sw_level = 1'b1;
  logic        cfg_multi = 1'b0;
  logic [15:0] cfg_len_m1 = 16'd0;
  logic        tx_en = 1'b0, rx_en = 1'b1, rx_ready = 1'b1;
  logic [2:0]  irq_en = 3'b111, sts_clr = 3'b000;
  logic [2:0]  sts;
  logic        irq, tx_valid, tx_ready, rx_valid, sck, mosi, cs;
  logic        miso = 1'b0;
  logic [31:0] tx_data, rx_data;

  spi_xfer_engine uut (.*);

  int total = 0, bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // transmit stream source
  logic [31:0] txq [16];
  int tx_wr = 0, tx_rd = 0;
  assign tx_valid = (tx_rd != tx_wr);
  assign tx_data  = txq[tx_rd % 16];
  always @(posedge clk) if (tx_valid && tx_ready) tx_rd <= tx_rd + 1;

  // receive stream sink
  logic [31:0] rxq [16];
  int rx_cnt = 0;
  always @(posedge clk) if (rx_valid && rx_ready) begin
    rxq[rx_cnt % 16] <= rx_data;
    rx_cnt <= rx_cnt + 1;
  end

  // slave-side model
  int bn = 8;
  logic bmsb = 1'b1;
  logic [31:0] cap [8];
  int k = 0, e = 0, cs_starts = 0;
  time t1 = 0, t2 = 0;
  logic cs_prev = 1'b0, sck_prev = 1'b0;
  wire cs_act = (cs != cfg_cs_idle);

  function automatic int bpos(input int b);
    return bmsb ? bn - 1 - b : b;
  endfunction
  function automatic logic [31:0] wmask();
    return (bn == 32) ? 32'hFFFF_FFFF : ((32'h1 << bn) - 32'h1);
  endfunction
  function automatic logic [31:0] slv_word(input int w);
    return (32'hA5C3_3C5A ^ (32'h0101_0101 * w)) & wmask();
  endfunction
  function automatic logic [31:0] mst_word(input int w);
    return (32'h1234_5678 + 32'h2F1E_3D4C * w) & wmask();
  endfunction
  function automatic logic slv_bit(input int kk);
    logic [31:0] sw;
    sw = slv_word(kk / bn);
    return sw[bpos(kk % bn)];
  endfunction

  always @(sck or cs_act) begin
    if (cs_act && !cs_prev) begin
      k = 0; e = 0; cs_starts++;
      for (int i = 0; i < 8; i++) cap[i] = '0;
      miso = slv_bit(0);
    end
    if ((sck !== sck_prev) && cs_act) begin
      e++;
      if (e == 1) t1 = $time;
      if (e == 2) t2 = $time;
      if (sck != cfg_drive_rise) begin
        cap[(k / bn) % 8][bpos(k % bn)] = mosi;
        k++;
        miso = slv_bit(k);
      end
    end
    cs_prev  = cs_act;
    sck_prev = sck;
  end

  task automatic set_cfg(input logic [1:0] ws, input int div, input logic idle,
                         input logic dr, input logic msb);
    @(negedge clk);
    cfg_wsize = ws; cfg_div = 16'(div); cfg_clk_idle = idle;
    cfg_drive_rise = dr; cfg_msb_first = msb;
    bn = (ws == 0) ? 8 : (ws == 1) ? 12 : (ws == 2) ? 16 : 32;
    bmsb = msb;
    repeat (3) @(negedge clk);
    sts_clr = 3'b111;
    @(negedge clk);
    sts_clr = 3'b000;
  endtask

  // push npush words, run a frame, wait for chip select release
  task automatic launch(input int npush, input logic multi, input int lenm1);
    int cs0;
    for (int w = 0; w < npush; w++) begin
      txq[tx_wr % 16] = mst_word(w);
      tx_wr++;
    end
    cfg_multi = multi; cfg_len_m1 = 16'(lenm1);
    cs0 = cs_starts;
    tx_en = 1'b1;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (cs_starts > cs0 && !cs_act) break;
    end
    tx_en = 1'b0;
    chk("R6 one chip-select window per frame", 32'(cs_starts - cs0), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_frame(input string tag, input logic [1:0] ws, input int div,
                         input logic idle, input logic dr, input logic msb, input int nw);
    int rx0;
    set_cfg(ws, div, idle, dr, msb);
    rx0 = rx_cnt;
    if (nw == 1) launch(1, 1'b0, 5);
    else         launch(nw, 1'b1, nw - 1);
    $display("scenario %s", tag);
    chk("R1 edge count", 32'(e), 32'(2 * bn * nw));
    chk("R2 half period", 32'((t2 - t1) / 10), 32'(div + 1));
    chk("R2 sck idle after frame", {31'd0, sck}, {31'd0, idle});
    chk("R5 words received", 32'(rx_cnt - rx0), 32'(nw));
    chk("R5 words taken", 32'(tx_wr - tx_rd), 32'd0);
    for (int w = 0; w < nw; w++) begin
      chk("R3 R4 mosi word", cap[w], mst_word(w));
      chk("R1 R4 rx word", rxq[(rx0 + w) % 16], slv_word(w));
    end
    chk("R8 frame end flag", {29'd0, sts}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R11 reset status", {29'd0, sts}, 32'd0);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);
    chk("R6 reset cs idle", {31'd0, cs}, 32'd1);
    chk("R2 reset sck", {31'd0, sck}, 32'd0);
    chk("R12 reset tx_ready", {31'd0, tx_ready}, 32'd0);
    chk("R9 reset rx_valid", {31'd0, rx_valid}, 32'd0);
  endtask

  task automatic t_overflow_and_irq();
    int rx0;
    set_cfg(2'd0, 0, 1'b0, 1'b0, 1'b1);
    rx_ready = 1'b0;
    rx0 = rx_cnt;
    launch(2, 1'b1, 1);
    chk("R9 overflow flag", {29'd0, sts}, 32'd3);
    chk("R9 pending kept", {31'd0, rx_valid}, 32'd1);
    chk("R9 pending word", rx_data, slv_word(0));
    rx_ready = 1'b1;
    @(negedge clk);
    chk("R9 one word delivered", 32'(rx_cnt - rx0), 32'd1);
    chk("R9 delivered first word", rxq[rx0 % 16], slv_word(0));
    irq_en = 3'b100;
    @(negedge clk);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
    irq_en = 3'b010;
    @(negedge clk);
    chk("R11 irq enabled", {31'd0, irq}, 32'd1);
    sts_clr = 3'b010;
    @(negedge clk);
    sts_clr = 3'b000;
    chk("R11 clear one bit", {29'd0, sts}, 32'd1);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R11 flag stays set", {29'd0, sts}, 32'd1);
    irq_en = 3'b111;
  endtask

  task automatic t_underflow();
    set_cfg(2'd0, 1, 1'b0, 1'b1, 1'b1);
    launch(1, 1'b1, 2);
    chk("R10 underflow flag only", {29'd0, sts}, 32'd4);
    chk("R10 frame cut after one word", 32'(e), 32'(2 * bn));
    chk("R10 cs idle", {31'd0, cs}, 32'd1);
  endtask

  task automatic t_rx_disabled();
    int rx0;
    set_cfg(2'd0, 0, 1'b0, 1'b0, 1'b0);
    rx_en = 1'b0; rx_ready = 1'b0;
    rx0 = rx_cnt;
    launch(2, 1'b1, 1);
    chk("R12 no overflow with rx off", {29'd0, sts}, 32'd1);
    chk("R12 nothing offered", {31'd0, rx_valid}, 32'd0);
    rx_en = 1'b1; rx_ready = 1'b1;
    @(negedge clk);
    chk("R12 nothing received", 32'(rx_cnt - rx0), 32'd0);
  endtask

  task automatic t_tx_disabled();
    int cs0;
    set_cfg(2'd0, 0, 1'b0, 1'b0, 1'b1);
    cs0 = cs_starts;
    txq[tx_wr % 16] = 32'h5A; tx_wr++;
    repeat (40) @(negedge clk);
    chk("R12 no frame while disabled", 32'(cs_starts - cs0), 32'd0);
    chk("R12 tx_ready low", {31'd0, tx_ready}, 32'd0);
    chk("R12 word left in source", 32'(tx_wr - tx_rd), 32'd1);
    tx_en = 1'b1;
    repeat (60) @(negedge clk);
    tx_en = 1'b0;
    chk("R12 frame after enable", 32'(cs_starts - cs0), 32'd1);
  endtask

  task automatic t_sw_cs();
    @(negedge clk);
    cfg_cs_sw_mode = 1'b1; cfg_cs_sw_level = 1'b0;
    @(negedge clk);
    chk("R7 sw cs low", {31'd0, cs}, 32'd0);
    cfg_cs_sw_level = 1'b1;
    @(negedge clk);
    chk("R7 sw cs high", {31'd0, cs}, 32'd1);
    cfg_cs_sw_mode = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame("8b mode0 msb", 2'd0, 1, 1'b0, 1'b0, 1'b1, 1);
    t_frame("12b mode3 lsb x3", 2'd1, 0, 1'b1, 1'b0, 1'b0, 3);
    t_frame("16b mode1 msb x2", 2'd2, 3, 1'b0, 1'b1, 1'b1, 2);
    t_frame("32b mode2 lsb", 2'd3, 1, 1'b1, 1'b1, 1'b0, 1);
    t_overflow_and_irq();
    t_underflow();
    t_rx_disabled();
    t_tx_disabled();
    t_sw_cs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule